// File: doc/BRIEF.md
# Delay-Element Period Calculator

This block turns the raw results of a delay-line calibration into the delay of one element of that line. Three operands are sampled on a start pulse: the period value of the reference clock, the count measured through the delay line, and the count measured on the reference clock. A select input chooses the element type. The type sets a constant denominator: 88 for a coarse element and 264 for a fine one.

The numerator N is the reference count times the period. The divisor D is the delay-line count times the denominator. The result is five times the integer quotient of N by D, plus a remainder term. That term is ten times the remainder, divided by twice D. Splitting the work this way keeps every intermediate value within 32 bits and keeps the fractional part that a single division would throw away. One restoring divider, one quotient bit per cycle, does both divisions in turn.

A zero delay-line count bypasses the divider, and the result is zero. A zero result of any kind marks a calibration that cannot be used. A zero flag and a two-bit failure code come out with the done pulse, and the code tells a failed coarse calculation from a failed fine one.

Top module: `dpc_period_calc`

## Requirements
- R1: While reset is asserted and after it is released, done_o, delay_o, zero_o and err_code_o are all 0 until the first calculation completes.
- R2: For a nonzero delay count, delay_o equals 5*floor(N/D) + floor(10*(N mod D)/(2*D)), with N = ref_cnt_i*refclk_per_i and D = dly_cnt_i*den. The remainder term alone can reach 4.
- R3: The denominator is 88 when fine_i = 0 (coarse) and 264 when fine_i = 1 (fine). The operands and fine_i are taken in the cycle where start_i is accepted.
- R4: If dly_cnt_i is 0, no division is done, delay_o is 0, and done_o rises on the first clock edge after the edge that accepts start_i.
- R5: Otherwise done_o rises on the 2*W+3 th edge after the accepting edge, with W = 2*OPW. This is edge 67 for the defaults.
- R6: done_o is high for exactly one cycle. delay_o, zero_o and err_code_o hold their values until the next done.
- R7: With done_o, zero_o is 1 exactly when delay_o is 0. This includes a zero result produced by division, such as a zero reference count.
- R8: err_code_o is 2'b00 when the result is nonzero. It is 2'b01 for a zero result with a coarse element and 2'b10 for a zero result with a fine element.
- R9: A start_i pulse while a calculation is running is ignored. It causes no extra done, and the running result is not changed.
- R10: The full 16-bit operand range works without overflow. The largest case is ref_cnt_i = refclk_per_i = 0xFFFF with dly_cnt_i = 1, coarse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to start a calculation |
| fine_i | input | 1 | Element type: 0 coarse (88), 1 fine (264) |
| refclk_per_i | input | 16 | Reference clock period value |
| dly_cnt_i | input | 16 | Count measured through the delay line |
| ref_cnt_i | input | 16 | Count measured on the reference clock |
| done_o | output | 1 | One-cycle pulse: the result is valid |
| delay_o | output | 32 | Per-element delay result |
| zero_o | output | 1 | Result is zero (invalid calibration) |
| err_code_o | output | 2 | 00 ok, 01 coarse failure, 10 fine failure |

## Verification
When the delay count is zero, the result is due one edge after the edge that takes the start. Every other case runs both divisions, and its result is due 67 edges after that edge. The driver writes down the number of the edge that samples each start, then queues the expected value together with the edge on which done must appear. The monitor samples on falling edges. For each done it compares the edge counter with the queued edge, and it flags any done that arrives when nothing is expected, so an ignored start that wrongly launches a run is caught.

// File: rtl/dpc_pkg.sv
// Package: shared state encoding and failure codes of the period calculator.
package dpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_DIV1 = 2'd2,
        ST_DIV2 = 2'd3
    } dpc_state_t;

    localparam logic [1:0] ERR_NONE   = 2'b00;
    localparam logic [1:0] ERR_COARSE = 2'b01;
    localparam logic [1:0] ERR_FINE   = 2'b10;

endpackage

// File: rtl/dpc_seq_div.sv
// Module: dpc_seq_div
// Restoring unsigned divider that produces one quotient bit per clock.
// A load captures the operands. W cycles later, done pulses for one
// cycle with the quotient and remainder valid, and they stay valid until
// the next load.
// Assumes: load is asserted only while busy is low, and the divisor is nonzero.
module dpc_seq_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  b_q;
    logic [CW-1:0] cnt;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    // Shift in the next dividend bit and try a subtraction of the divisor.
    always_comb begin
        shifted = {rem, quo[W-1]};
        trial   = shifted - {1'b0, b_q};
    end

    // Iteration register: load, then W restoring steps, then the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            quo  <= '0;
            b_q  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                rem  <= '0;
                quo  <= dividend;
                b_q  <= divisor;
                cnt  <= CW'(W);
                busy <= 1'b1;
            end else if (busy) begin
                if (!trial[W]) begin
                    rem <= trial[W-1:0];
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= shifted[W-1:0];
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dpc_operand.sv
// Module: dpc_operand
// Holds the operands taken at an accepted start, and from them forms the
// numerator (reference count times period) and the divisor (delay count
// times the element denominator). It also raises the zero-operand guard.
// Assumes: capture is asserted only while the calculator is idle.
// Both products fit in W = 2*OPW bits.
module dpc_operand #(
    parameter int OPW        = 16,
    parameter int W          = 2 * OPW,
    parameter int DEN_COARSE = 88,
    parameter int DEN_FINE   = 264
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture,
    input  logic           fine_i,
    input  logic [OPW-1:0] per_i,
    input  logic [OPW-1:0] dly_i,
    input  logic [OPW-1:0] ref_i,
    output logic [W-1:0]   num,
    output logic [W-1:0]   dvs,
    output logic           guard,
    output logic           fine_q
);
    localparam logic [OPW-1:0] DC = OPW'(DEN_COARSE);
    localparam logic [OPW-1:0] DF = OPW'(DEN_FINE);

    logic [OPW-1:0] per_q;
    logic [OPW-1:0] dly_q;
    logic [OPW-1:0] ref_q;
    logic [OPW-1:0] den;

    // Operand register: loaded only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q  <= '0;
            dly_q  <= '0;
            ref_q  <= '0;
            fine_q <= 1'b0;
        end else if (capture) begin
            per_q  <= per_i;
            dly_q  <= dly_i;
            ref_q  <= ref_i;
            fine_q <= fine_i;
        end
    end

    // Products and guard formed from the held operands.
    always_comb begin
        den   = fine_q ? DF : DC;
        num   = W'(ref_q) * W'(per_q);
        dvs   = W'(dly_q) * W'(den);
        guard = (dly_q == '0) || (den == '0);
    end

endmodule

// File: rtl/dpc_period_calc.sv
// Module: dpc_period_calc (top)
// Per-element delay calculator. The result is 5*(N/D) plus
// (10*(N mod D))/(2*D). N is the reference count times the period and D
// is the delay count times the element denominator. One shared divider
// forms the first quotient, then it forms the remainder term.
// A zero delay count skips the divider and returns zero.
// Assumes: 2*D and 10*(N mod D) fit in W bits. This holds for the
// default denominators.
module dpc_period_calc #(
    parameter int OPW        = 16,
    parameter int DEN_COARSE = 88,
    parameter int DEN_FINE   = 264
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            fine_i,
    input  logic [OPW-1:0]  refclk_per_i,
    input  logic [OPW-1:0]  dly_cnt_i,
    input  logic [OPW-1:0]  ref_cnt_i,
    output logic            done_o,
    output logic [2*OPW-1:0] delay_o,
    output logic            zero_o,
    output logic [1:0]      err_code_o
);
    import dpc_pkg::*;

    localparam int W = 2 * OPW;

    dpc_state_t   state;
    logic         busy;
    logic         accept;
    logic [W-1:0] num;
    logic [W-1:0] dvs;
    logic         guard;
    logic         fine_q;
    logic         div_load;
    logic [W-1:0] div_a;
    logic [W-1:0] div_b;
    logic         div_busy;
    logic         div_done;
    logic [W-1:0] div_quo;
    logic [W-1:0] div_rem;
    logic [W-1:0] q_term;
    logic [W-1:0] fin_sum;
    logic [1:0]   fail_code;

    assign busy   = (state != ST_IDLE);
    assign accept = start_i && !busy;

    dpc_operand #(
        .OPW        (OPW),
        .W          (W),
        .DEN_COARSE (DEN_COARSE),
        .DEN_FINE   (DEN_FINE)
    ) u_operand (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .fine_i  (fine_i),
        .per_i   (refclk_per_i),
        .dly_i   (dly_cnt_i),
        .ref_i   (ref_cnt_i),
        .num     (num),
        .dvs     (dvs),
        .guard   (guard),
        .fine_q  (fine_q)
    );

    // Divider operand mux: first the main division, then the remainder term.
    always_comb begin
        div_load = ((state == ST_PREP) && !guard) ||
                   ((state == ST_DIV1) && div_done);
        if (state == ST_PREP) begin
            div_a = num;
            div_b = dvs;
        end else begin
            div_a = (div_rem << 3) + (div_rem << 1);
            div_b = dvs << 1;
        end
        fin_sum   = q_term + div_quo;
        fail_code = fine_q ? ERR_FINE : ERR_COARSE;
    end

    dpc_seq_div #(
        .W (W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .dividend (div_a),
        .divisor  (div_b),
        .busy     (div_busy),
        .done     (div_done),
        .quo      (div_quo),
        .rem      (div_rem)
    );

    // Sequencer: accept, guard or divide twice, then publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            q_term     <= '0;
            delay_o    <= '0;
            zero_o     <= 1'b0;
            err_code_o <= ERR_NONE;
            done_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) state <= ST_PREP;
                end
                ST_PREP: begin
                    if (guard) begin
                        delay_o    <= '0;
                        zero_o     <= 1'b1;
                        err_code_o <= fail_code;
                        done_o     <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        state <= ST_DIV1;
                    end
                end
                ST_DIV1: begin
                    if (div_done) begin
                        q_term <= (div_quo << 2) + div_quo;
                        state  <= ST_DIV2;
                    end
                end
                ST_DIV2: begin
                    if (div_done && !div_busy) begin
                        delay_o    <= fin_sum;
                        zero_o     <= (fin_sum == '0);
                        err_code_o <= (fin_sum == '0) ? fail_code : ERR_NONE;
                        done_o     <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dpc_period_calc_chk.sv
// Module: dpc_period_calc_chk
// Assertion checker bound to the calculator. It relates the done pulse to
// the accepted start, the result to its flags, and the held outputs over time.
// Assumes: the default denominators are nonzero, so only a zero delay count
// takes the guard path.
module dpc_period_calc_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         fine_i,
    input logic [W/2-1:0] dly_cnt_i,
    input logic         busy,
    input logic         done_o,
    input logic [W-1:0] delay_o,
    input logic         zero_o,
    input logic [1:0]   err_code_o
);
    import dpc_pkg::*;

    localparam int LAT_FULL = 2 * W + 3;
    localparam int CW       = $clog2(LAT_FULL + 2) + 1;

    logic          in_run;
    logic          grd_q;
    logic          fine_seen;
    logic [CW-1:0] run_cnt;

    // Count edges from the accepted start to its done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_run    <= 1'b0;
            grd_q     <= 1'b0;
            fine_seen <= 1'b0;
            run_cnt   <= '0;
        end else if (start_i && !busy) begin
            in_run    <= 1'b1;
            grd_q     <= (dly_cnt_i == '0);
            fine_seen <= fine_i;
            run_cnt   <= '0;
        end else if (done_o) begin
            in_run <= 1'b0;
        end else if (in_run) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (in_run && (run_cnt == (grd_q ? CW'(1) : CW'(LAT_FULL)))));

    p_guard_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && grd_q) |-> (delay_o == '0));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(delay_o) && $stable(zero_o) && $stable(err_code_o)));

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (zero_o == (delay_o == '0)));

    p_err_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (err_code_o == (!zero_o ? ERR_NONE :
                                   (fine_seen ? ERR_FINE : ERR_COARSE))));

endmodule

bind dpc_period_calc dpc_period_calc_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .fine_i     (fine_i),
    .dly_cnt_i  (dly_cnt_i),
    .busy       (busy),
    .done_o     (done_o),
    .delay_o    (delay_o),
    .zero_o     (zero_o),
    .err_code_o (err_code_o)
);

// File: tb/dpc_period_calc_bench.sv
// Scoreboard bench: a driver queues the expected result and its due edge;
// a monitor pops and compares on each done, sampling on falling edges.
module dpc_period_calc_bench;

    localparam int OPW      = 16;
    localparam int LAT_FULL = 2 * (2 * OPW) + 3;
    localparam int LAT_GRD  = 1;

    typedef struct {
        longint res;
        bit     z;
        int     e;
        int     due;
        string  tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            fine_i = 1'b0;
    logic [OPW-1:0]  refclk_per_i = '0;
    logic [OPW-1:0]  dly_cnt_i = '0;
    logic [OPW-1:0]  ref_cnt_i = '0;
    logic            done_o;
    logic [2*OPW-1:0] delay_o;
    logic            zero_o;
    logic [1:0]      err_code_o;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   n_done = 0;
    exp_t sb[$];
    longint last_res = 0;

    dpc_period_calc #(.OPW(OPW)) u_dpc_period_calc (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .fine_i       (fine_i),
        .refclk_per_i (refclk_per_i),
        .dly_cnt_i    (dly_cnt_i),
        .ref_cnt_i    (ref_cnt_i),
        .done_o       (done_o),
        .delay_o      (delay_o),
        .zero_o       (zero_o),
        .err_code_o   (err_code_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic longint model(input longint per, input longint dly, input longint rf, input bit fine);
        longint n;
        longint d;
        n = rf * per;
        d = dly * (fine ? 264 : 88);
        if (d == 0) return 0;
        return 5 * (n / d) + (10 * (n % d)) / (2 * d);
    endfunction

    // Driver: apply one request and queue its expectation.
    task automatic run_calc(input bit fine, input int per, input int dly, input int rf, input string tag);
        exp_t x;
        @(negedge clk);
        fine_i       = fine;
        refclk_per_i = OPW'(per);
        dly_cnt_i    = OPW'(dly);
        ref_cnt_i    = OPW'(rf);
        start_i      = 1'b1;
        x.res = model(per, dly, rf, fine);
        x.z   = (x.res == 0);
        x.e   = x.z ? (fine ? 2 : 1) : 0;
        x.due = cyc + 1 + ((dly == 0) ? LAT_GRD : LAT_FULL);
        x.tag = tag;
        sb.push_back(x);
        @(negedge clk);
        start_i = 1'b0;
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: compare each done against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            exp_t x;
            n_done++;
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                x = sb.pop_front();
                check(delay_o == x.res, {x.tag, " R2 delay"}, delay_o, x.res);
                check(zero_o == x.z, {x.tag, " R7 zero flag"}, zero_o, x.z);
                check(err_code_o == x.e, {x.tag, " R8 err code"}, err_code_o, x.e);
                check(cyc == x.due, {x.tag, " R5 due edge"}, cyc, x.due);
                last_res = x.res;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int dn;
        repeat (3) @(negedge clk);
        check(done_o == 1'b0 && delay_o == '0 && zero_o == 1'b0 && err_code_o == 2'b00,
              "R1 reset state in reset", delay_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done_o == 1'b0 && delay_o == '0 && zero_o == 1'b0 && err_code_o == 2'b00,
              "R1 reset state after release", delay_o, 0);

        run_calc(1'b0, 2500, 100, 1000, "R2 R3 coarse");
        run_calc(1'b1, 2500, 100, 1000, "R3 fine");
        run_calc(1'b0, 87, 1, 1, "R2 remainder term 4");
        run_calc(1'b1, 16'h1234, 16'h0457, 16'h9abc, "R2 mixed fine");
        run_calc(1'b0, 16'h0fed, 16'h0033, 16'h7001, "R2 mixed coarse");
        run_calc(1'b0, 16'hffff, 1, 16'hffff, "R10 max coarse");
        run_calc(1'b1, 16'hffff, 16'hffff, 16'hffff, "R10 max fine");
        run_calc(1'b0, 1234, 0, 999, "R4 guard coarse");
        run_calc(1'b1, 1234, 0, 999, "R4 guard fine");
        run_calc(1'b0, 500, 5, 0, "R7 zero ref coarse");
        run_calc(1'b1, 0, 9, 300, "R8 zero period fine");

        // R6: outputs hold after done, and done is one cycle wide.
        run_calc(1'b0, 3000, 7, 4000, "R6 hold setup");
        repeat (5) @(negedge clk);
        check(delay_o == last_res, "R6 delay held", delay_o, last_res);
        check(done_o == 1'b0, "R6 done single cycle", done_o, 0);

        // R9: a second start during a run is ignored.
        dn = n_done;
        begin
            exp_t x;
            @(negedge clk);
            fine_i = 1'b0; refclk_per_i = 16'd777; dly_cnt_i = 16'd3; ref_cnt_i = 16'd555;
            start_i = 1'b1;
            x.res = model(777, 3, 555, 1'b0);
            x.z = (x.res == 0);
            x.e = 0;
            x.due = cyc + 1 + LAT_FULL;
            x.tag = "R9 first run";
            sb.push_back(x);
            @(negedge clk);
            start_i = 1'b0;
            repeat (10) @(negedge clk);
            fine_i = 1'b1; refclk_per_i = 16'd1; dly_cnt_i = 16'd0; ref_cnt_i = 16'd1;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            wait (sb.size() == 0);
            repeat (2 * LAT_FULL) @(negedge clk);
        end
        check(n_done == dn + 1, "R9 done count", n_done, dn + 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule